// File: doc/BRIEF.md
# Performance Monitor Register File

This block holds the performance-monitor state of a processor core: two mode-control words, four 32-bit event counters and a sample-address register. Software reaches these registers through move-to and move-from special-purpose-register requests. Each request carries a 10-bit register number, a direction, write data and the privilege mode of the requester. The block decodes the number and checks the privilege. It then either performs the access or raises a program-interrupt flag. Every supervisor register also appears at a second number as a read-only alias, so that user-mode code can read the monitor without the right to change it.

Outside the access port, each counter advances by one on every cycle its event input is high. When the core takes a monitor exception, the sample-address register records the address of the instruction that completed in that same cycle. If nothing completed in that cycle, the register keeps its old value.

The block does not select events, vector interrupts or synchronize the pipeline. It returns read data and the fault flag one cycle after the request.

Top module: `pmon_regfile`

## Requirements
- R1: After synchronous reset every register reads zero, and `acc_fault` and `acc_rdata` are zero.
- R2: The register number is split into a 5-bit upper half, which must be 11101, and a 5-bit lower half. Supervisor numbers 952..958 address, in order: control 0, counter 1, counter 2, sample address, control 1, counter 3, counter 4. A supervisor-mode access to one of them is legal. A read returns the register on `acc_rdata` in the cycle after the request, with `acc_fault` low. A write updates the register at the request edge.
- R3: Alias numbers 936..942 map to the same seven registers in the same order. A read of an alias in either mode returns exactly the value of the matching supervisor register, with no fault.
- R4: Any write to an alias number 936..942, in user or supervisor mode, sets `acc_fault` in the next cycle and changes no register.
- R5: A user-mode read or write of a number in 952..958 sets `acc_fault` in the next cycle. `acc_rdata` is zero in that cycle and no register changes.
- R6: Numbers 943 and 959 belong to the decoded group but hold no register. Any access to them, in either mode and either direction, faults.
- R7: An access to any number outside 936..943 and 952..959 is ignored. `acc_fault` stays low, `acc_rdata` is zero and no register changes.
- R8: Counter k (k = 1..4) increments by one at every edge where `evt_inc[k-1]` is high, and wraps from 0xFFFFFFFF to 0.
- R9: A legal supervisor write to a counter in the same cycle as its event input loads the written value, and the increment is lost.
- R10: When `exc_taken` and `cmp_valid` are both high, the sample-address register is loaded with `cmp_addr`.
- R11: When `exc_taken` is high and `cmp_valid` is low, the sample-address register keeps its value.
- R12: A legal supervisor write to the sample-address register takes priority over a capture in the same cycle.
- R13: `acc_fault` is a one-cycle pulse for each faulting request. `acc_rdata` is zero in every cycle that does not follow a legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access request present |
| acc_num | input | 10 | Register number of the request |
| acc_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| acc_wdata | input | 32 | Write data |
| acc_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| acc_rdata | output | 32 | Read data, one cycle after a legal read, otherwise zero |
| acc_fault | output | 1 | Program-interrupt flag, one cycle after an illegal request |
| cmp_valid | input | 1 | An instruction completed this cycle |
| cmp_addr | input | 32 | Address of the completing instruction |
| evt_inc | input | 4 | Per-counter event input, bit k drives counter k+1 |
| exc_taken | input | 1 | Monitor exception taken this cycle |

## Verification
A corrupted register is invisible at the ports until it is read through one of its two numbers. The value then appears on `acc_rdata` exactly one cycle after the read request. A decode error shows up one cycle after the request as a wrong `acc_fault` pulse or as data where zero is expected. A write that lands in the wrong register, or slips through an alias, only surfaces at the next read-back of the register it touched. For that reason every sweep of writes is broken up by full read-backs through the alias numbers. A capture or increment taken on the wrong edge shifts the read-back value by one address or one count.

// File: rtl/pmon_pkg.sv
// pmon_pkg: shared constants, slot encoding and decode result type
// for the performance-monitor register file. The register-number
// layout is fixed by the architecture, so it is not parameterised.
package pmon_pkg;

    localparam int SPR_W     = 10;          // register number width
    localparam int HALF_W    = 5;           // width of each half
    localparam logic [HALF_W-1:0] SPR_HI = 5'b11101; // common upper half
    localparam int SPACE_BIT = 4;           // 1 = supervisor, 0 = alias
    localparam int GROUP_BIT = 3;           // must be 1 for this block
    localparam int SLOT_W    = 3;
    localparam int NUM_SLOTS = 1 << SLOT_W; // slot 7 holds no register
    localparam int NUM_CNT   = 4;
    localparam int NUM_CTL   = 2;

    // Slot order within each space; the order is architectural.
    typedef enum logic [SLOT_W-1:0] {
        SLOT_CTL0   = 3'd0,
        SLOT_CNT1   = 3'd1,
        SLOT_CNT2   = 3'd2,
        SLOT_SAMPLE = 3'd3,
        SLOT_CTL1   = 3'd4,
        SLOT_CNT3   = 3'd5,
        SLOT_CNT4   = 3'd6,
        SLOT_NONE   = 3'd7
    } slot_e;

    // Decode outcome of one access request.
    typedef struct packed {
        logic              hit;    // number belongs to this block
        logic              fault;  // program-interrupt condition
        logic              rd_ok;  // legal read
        logic              wr_ok;  // legal write
        logic [SLOT_W-1:0] slot;   // register slot addressed
    } dec_t;

    // Slot of counter k (0-based).
    function automatic logic [SLOT_W-1:0] cnt_slot(input int k);
        case (k)
            0:       return SLOT_CNT1;
            1:       return SLOT_CNT2;
            2:       return SLOT_CNT3;
            default: return SLOT_CNT4;
        endcase
    endfunction

    // Slot of control register k (0-based).
    function automatic logic [SLOT_W-1:0] ctl_slot(input int k);
        return (k == 0) ? SLOT_CTL0 : SLOT_CTL1;
    endfunction

    // Full supervisor number of a slot.
    function automatic logic [SPR_W-1:0] super_num(input logic [SLOT_W-1:0] s);
        return {SPR_HI, 1'b1, 1'b1, s};
    endfunction

endpackage

// File: rtl/pmon_spr_decode.sv
// pmon_spr_decode: combinational decode of a register access request.
// Classifies a request as outside the block, legal read, legal write
// or fault. Assumes the request fields are stable while req_valid is high.
module pmon_spr_decode
    import pmon_pkg::*;
(
    input  logic             req_valid,
    input  logic [SPR_W-1:0] req_num,
    input  logic             req_write,
    input  logic             req_super,
    output dec_t             dec
);

    logic in_group;
    logic alias_sel;
    logic unmapped;

    // Split the number into its fields and classify the access.
    always_comb begin
        in_group  = req_valid
                    && (req_num[SPR_W-1 -: HALF_W] == SPR_HI)
                    && req_num[GROUP_BIT];
        alias_sel = !req_num[SPACE_BIT];
        unmapped  = (req_num[SLOT_W-1:0] == SLOT_NONE);
        dec.hit   = in_group;
        dec.slot  = req_num[SLOT_W-1:0];
        dec.fault = in_group && (unmapped
                                 || (alias_sel && req_write)
                                 || (!alias_sel && !req_super));
        dec.rd_ok = in_group && !dec.fault && !req_write;
        dec.wr_ok = in_group && !dec.fault && req_write;
    end

endmodule

// File: rtl/pmon_event_counter.sv
// pmon_event_counter: one event counter with a direct load.
// A load in the same cycle as an event wins; the count wraps at 2^W.
module pmon_event_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q
);

    // Load has priority over the event increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/pmon_sample_capture.sv
// pmon_sample_capture: sample-address register. It is loaded on a
// monitor exception only when an instruction completed in that cycle.
// A direct load in the same cycle takes priority over the capture.
module pmon_sample_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         exc,
    input  logic         cmp_valid,
    input  logic [W-1:0] cmp_addr,
    output logic [W-1:0] q
);

    // The write wins, then the capture; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (exc && cmp_valid) begin
            q <= cmp_addr;
        end
    end

endmodule

// File: rtl/pmon_regfile.sv
// pmon_regfile: performance-monitor register file. It holds two control
// words, NUM_CNT event counters and the sample-address register, decodes
// register accesses and answers one cycle later with read data or a
// fault pulse. Assumes cmp_addr is as wide as the data path.
module pmon_regfile
    import pmon_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SPR_W-1:0] acc_num,
    input  logic             acc_write,
    input  logic [DW-1:0]    acc_wdata,
    input  logic             acc_super,
    output logic [DW-1:0]    acc_rdata,
    output logic             acc_fault,
    input  logic             cmp_valid,
    input  logic [DW-1:0]    cmp_addr,
    input  logic [NUM_CNT-1:0] evt_inc,
    input  logic             exc_taken
);

    dec_t                 dec;
    logic [NUM_SLOTS-1:0] wr_en;
    logic [DW-1:0]        ctl_q   [NUM_CTL];
    logic [DW-1:0]        cnt_q   [NUM_CNT];
    logic [DW-1:0]        smp_q;
    logic [DW-1:0]        slot_val[NUM_SLOTS];

    pmon_spr_decode u_dec (
        .req_valid (acc_valid),
        .req_num   (acc_num),
        .req_write (acc_write),
        .req_super (acc_super),
        .dec       (dec)
    );

    // One write-enable per slot, only for legal writes.
    always_comb begin
        wr_en = '0;
        if (dec.wr_ok) begin
            wr_en[dec.slot] = 1'b1;
        end
    end

    // Control words: plain storage written by legal writes.
    for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
        localparam logic [SLOT_W-1:0] SL = ctl_slot(c);
        // Hold or load control word c.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[c] <= '0;
            end else if (wr_en[SL]) begin
                ctl_q[c] <= acc_wdata;
            end
        end
    end

    // Event counters.
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        localparam logic [SLOT_W-1:0] SL = cnt_slot(k);
        pmon_event_counter #(.W(DW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (wr_en[SL]),
            .ld_val (acc_wdata),
            .inc    (evt_inc[k]),
            .q      (cnt_q[k])
        );
    end

    pmon_sample_capture #(.W(DW)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (wr_en[SLOT_SAMPLE]),
        .ld_val    (acc_wdata),
        .exc       (exc_taken),
        .cmp_valid (cmp_valid),
        .cmp_addr  (cmp_addr),
        .q         (smp_q)
    );

    // Gather register values by slot for the read mux.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            slot_val[s] = '0;
        end
        for (int c = 0; c < NUM_CTL; c++) begin
            slot_val[ctl_slot(c)] = ctl_q[c];
        end
        for (int k = 0; k < NUM_CNT; k++) begin
            slot_val[cnt_slot(k)] = cnt_q[k];
        end
        slot_val[SLOT_SAMPLE] = smp_q;
    end

    // Register the response: data for a legal read, fault pulse otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata <= '0;
            acc_fault <= 1'b0;
        end else begin
            acc_rdata <= dec.rd_ok ? slot_val[dec.slot] : '0;
            acc_fault <= dec.fault;
        end
    end

endmodule

// File: rtl/pmon_regfile_chk.sv
// pmon_regfile_chk: temporal checks on the register file's ports and
// its stored counter and sample values. Bound into every pmon_regfile.
module pmon_regfile_chk
    import pmon_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SPR_W-1:0] acc_num,
    input  logic             acc_write,
    input  logic             acc_super,
    input  logic [DW-1:0]    acc_rdata,
    input  logic             acc_fault,
    input  logic             cmp_valid,
    input  logic [DW-1:0]    cmp_addr,
    input  logic [NUM_CNT-1:0] evt_inc,
    input  logic             exc_taken,
    input  logic [DW-1:0]    cnt_q [NUM_CNT],
    input  logic [DW-1:0]    smp_q
);

    logic grp;
    logic smp_wr;

    // Request falls inside this block's numbers; sample write request.
    always_comb begin
        grp    = acc_valid && (acc_num[SPR_W-1 -: HALF_W] == SPR_HI)
                 && acc_num[GROUP_BIT];
        smp_wr = acc_valid && acc_write && acc_super
                 && (acc_num == super_num(SLOT_SAMPLE));
    end

    // R4
    alias_write_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp && acc_write && !acc_num[SPACE_BIT] |=> acc_fault);

    // R5
    user_super_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp && !acc_super && acc_num[SPACE_BIT] |=> acc_fault && acc_rdata == '0);

    // R7
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp |=> !acc_fault && acc_rdata == '0);

    // R13
    fault_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> acc_rdata == '0);

    // R8
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_step
        localparam logic [SPR_W-1:0] NUMK = super_num(cnt_slot(k));
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_inc[k] && !(acc_valid && acc_write && acc_super && acc_num == NUMK)
            |=> cnt_q[k] == $past(cnt_q[k]) + DW'(1));
    end

    // R10
    sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken && cmp_valid && !smp_wr |=> smp_q == $past(cmp_addr));

    // R11
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken && !cmp_valid && !smp_wr |=> $stable(smp_q));

endmodule

bind pmon_regfile pmon_regfile_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_num   (acc_num),
    .acc_write (acc_write),
    .acc_super (acc_super),
    .acc_rdata (acc_rdata),
    .acc_fault (acc_fault),
    .cmp_valid (cmp_valid),
    .cmp_addr  (cmp_addr),
    .evt_inc   (evt_inc),
    .exc_taken (exc_taken),
    .cnt_q     (cnt_q),
    .smp_q     (smp_q)
);

// File: tb/sim_pmon_regfile.sv
`timescale 1ns/1ps
module sim_pmon_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [9:0]  acc_num = '0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        acc_super = 1'b0;
    logic [31:0] acc_rdata;
    logic        acc_fault;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_addr = '0;
    logic [3:0]  evt_inc = '0;
    logic        exc_taken = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [7];
    logic [31:0] got_d;
    logic        got_f;

    always #2 clk = ~clk;

    pmon_regfile u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_num(acc_num),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_super(acc_super),
        .acc_rdata(acc_rdata), .acc_fault(acc_fault), .cmp_valid(cmp_valid),
        .cmp_addr(cmp_addr), .evt_inc(evt_inc), .exc_taken(exc_taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request; response sampled at the next falling edge.
    task automatic access(input int num, input bit wr, input bit sup, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_num = 10'(num); acc_write = wr;
        acc_super = sup;  acc_wdata = d;
        @(negedge clk);
        got_d = acc_rdata; got_f = acc_fault;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Read all seven registers through the aliases (R3).
    task automatic verify_all(input string req);
        for (int i = 0; i < 7; i++) begin
            access(936 + i, 1'b0, 1'(i % 2), 32'h0);
            check({req, " R3 alias data"}, got_d, exp_q[i]);
            check({req, " R3 alias fault"}, 32'(got_f), 32'h0);
        end
    endtask

    function automatic bit in_blk(input int n);
        return (n / 32 == 29) && ((n % 16) >= 8);
    endfunction

    function automatic string tag_of(input int n, input bit wr, input bit sup);
        if (!in_blk(n)) return "R7";
        if (n % 8 == 7) return "R6";
        if ((n % 32) < 16) return wr ? "R4" : "R3";
        return sup ? "R2" : "R5";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) exp_q[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", acc_rdata, 32'h0);
        check("R1 fault", 32'(acc_fault), 32'h0);
        for (int i = 0; i < 7; i++) begin
            access(952 + i, 1'b0, 1'b1, 32'h0);
            check("R1 reg zero", got_d, 32'h0);
        end

        // Write sweep over every number in both modes.
        for (int n = 0; n < 1024; n++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] d;
                bit flt;
                d = 32'h9E3779B9 * 32'(n * 2 + s + 1);
                flt = in_blk(n) && ((n % 8 == 7) || ((n % 32) < 16) || (s == 0));
                access(n, 1'b1, 1'(s), d);
                check({tag_of(n, 1'b1, 1'(s)), " write fault"}, 32'(got_f), 32'(flt));
                check({tag_of(n, 1'b1, 1'(s)), " write rdata"}, got_d, 32'h0);
                if (in_blk(n) && !flt) exp_q[n % 8] = d;
                if (got_f) begin
                    @(negedge clk);
                    check("R13 fault pulse", 32'(acc_fault), 32'h0);
                end
            end
            if (n % 128 == 127) verify_all("sweep");
        end

        // Read sweep over every number in both modes.
        for (int n = 0; n < 1024; n++) begin
            for (int s = 0; s < 2; s++) begin
                bit flt;
                flt = in_blk(n) && ((n % 8 == 7) || ((n % 32) >= 16 && s == 0));
                access(n, 1'b0, 1'(s), 32'h0);
                check({tag_of(n, 1'b0, 1'(s)), " read fault"}, 32'(got_f), 32'(flt));
                check({tag_of(n, 1'b0, 1'(s)), " read data"}, got_d,
                      (in_blk(n) && !flt) ? exp_q[n % 8] : 32'h0);
            end
        end
        verify_all("after read sweep");

        // R8: every event pattern for one cycle each.
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            evt_inc = 4'(c);
            if (c % 2 == 1) exp_q[1] = exp_q[1] + 1;
            if ((c / 2) % 2 == 1) exp_q[2] = exp_q[2] + 1;
            if ((c / 4) % 2 == 1) exp_q[5] = exp_q[5] + 1;
            if ((c / 8) % 2 == 1) exp_q[6] = exp_q[6] + 1;
        end
        @(negedge clk);
        evt_inc = '0;
        verify_all("R8 increments");

        // R8: wrap of counter 4.
        access(958, 1'b1, 1'b1, 32'hFFFF_FFFF);
        @(negedge clk); evt_inc = 4'b1000;
        @(negedge clk); evt_inc = '0;
        access(942, 1'b0, 1'b0, 32'h0);
        check("R8 wrap", got_d, 32'h0);
        exp_q[6] = '0;

        // R9: write to counter 1 collides with its event; counter 2 still counts.
        @(negedge clk);
        acc_valid = 1'b1; acc_num = 10'd953; acc_write = 1'b1;
        acc_super = 1'b1; acc_wdata = 32'h1234_5678; evt_inc = 4'b0011;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; evt_inc = '0;
        exp_q[1] = 32'h1234_5678;
        exp_q[2] = exp_q[2] + 1;
        access(937, 1'b0, 1'b0, 32'h0);
        check("R9 write wins", got_d, 32'h1234_5678);
        verify_all("R9");

        // R10: capture with a completion.
        @(negedge clk);
        exc_taken = 1'b1; cmp_valid = 1'b1; cmp_addr = 32'h0000_4A40;
        @(negedge clk);
        exc_taken = 1'b0; cmp_valid = 1'b0; cmp_addr = 32'hDEAD_0000;
        access(939, 1'b0, 1'b0, 32'h0);
        check("R10 capture", got_d, 32'h0000_4A40);
        exp_q[3] = 32'h0000_4A40;

        // R11: exception with no completion keeps the sample.
        @(negedge clk);
        exc_taken = 1'b1; cmp_valid = 1'b0; cmp_addr = 32'h0000_7770;
        @(negedge clk);
        exc_taken = 1'b0;
        access(939, 1'b0, 1'b1, 32'h0);
        check("R11 hold", got_d, 32'h0000_4A40);

        // Completion without an exception also leaves it alone (R11).
        @(negedge clk);
        cmp_valid = 1'b1; cmp_addr = 32'h0000_8880;
        @(negedge clk);
        cmp_valid = 1'b0;
        access(955, 1'b0, 1'b1, 32'h0);
        check("R11 no exception", got_d, 32'h0000_4A40);

        // R12: supervisor write beats a capture in the same cycle.
        @(negedge clk);
        acc_valid = 1'b1; acc_num = 10'd955; acc_write = 1'b1;
        acc_super = 1'b1; acc_wdata = 32'hCAFE_0004;
        exc_taken = 1'b1; cmp_valid = 1'b1; cmp_addr = 32'h0000_9990;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; exc_taken = 1'b0; cmp_valid = 1'b0;
        exp_q[3] = 32'hCAFE_0004;
        access(939, 1'b0, 1'b0, 32'h0);
        check("R12 write priority", got_d, 32'hCAFE_0004);

        // R13: idle cycle after a legal read carries no data.
        @(negedge clk);
        check("R13 idle rdata", acc_rdata, 32'h0);
        check("R13 idle fault", 32'(acc_fault), 32'h0);
        verify_all("final");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule